// File: doc/BRIEF.md
# Memory Self-Refresh Power Sequencer

This block moves an external DDR2-style memory into its self-refresh low-power state and brings it back out, on behalf of the memory controller it sits in. Software starts the move by writing a control word with the self-refresh request bit set. The block then closes all open banks with a precharge-all command and waits out the precharge time. Next it issues the self-refresh entry command and drops the clock-enable pin. From that point the device refreshes itself, so the controller's auto-refresh scheduler is held off and the on-chip DLL is kept in reset.

Software polls a status bit to learn that self-refresh has been entered. Only after that may it stop individual memory clocks through per-clock disable bits. The device stays in self-refresh for at least a programmable residency time. After that, the first pending internal access starts the exit. The exit order is fixed: the clocks are ungated, clock-enable is raised, the DLL is released, and a programmable recovery time elapses. The held access is then released with a one-cycle grant, and the status and the refresh suppression drop in that same cycle.

Top module: `sr_power_ctrl`

## Requirements
- R1: After reset, cke is 1, every clk_en bit is 1, and cmd_pall, cmd_sre, sr_active, aref_block, dll_rst and acc_go are all 0.
- R2: A control write (ctl_we=1) with ctl_srf=1 while the block is idle makes cmd_pall high for exactly the one cycle that follows the write edge. aref_block rises in that same cycle.
- R3: After the precharge cycle, the block waits W(cfg_trp) cycles, where W(n)=n for n>=2 and W(n)=1 otherwise. It then raises cmd_sre for one cycle, and cke is 0 in that cycle.
- R4: cke stays 0 from the entry-command cycle until the second exit cycle. aref_block stays 1 from the precharge cycle until the grant cycle, where it drops together with sr_active.
- R5: sr_active is 1 from the entry-command cycle through the last recovery cycle, and is 0 in the grant cycle.
- R6: The self-refresh wait state lasts at least W(cfg_tras) cycles. It ends in the first cycle at or after that minimum in which acc_req is 1, and not before.
- R7: Bit k of ctl_clkdis set to 1 in a control write stops clock k, so clk_en[k]=0. Such a write is accepted only in the entry-command cycle or during the self-refresh wait. At any other time it is ignored and every clk_en bit stays 1.
- R8: Exit runs in this order. In the first exit cycle every clk_en bit is 1, cke is 0 and dll_rst is 1. In the next cycle cke is 1 and dll_rst is still 1. Then W(cfg_txsr) recovery cycles follow with dll_rst=0. The final cycle has acc_go=1 for one cycle.
- R9: A write with ctl_srf=1 outside the idle state does not start a new precharge or disturb the sequence. acc_req while idle never produces acc_go or a precharge.
- R10: dll_rst is 1 from the entry-command cycle until the cycle after cke is raised on exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_srf | input | 1 | Control word: self-refresh request bit |
| ctl_clkdis | input | NCLK | Control word: per-clock stop bits (1 stops the clock) |
| cfg_trp | input | CW | Precharge wait count |
| cfg_tras | input | CW | Minimum self-refresh residency count |
| cfg_txsr | input | CW | Exit recovery count |
| acc_req | input | 1 | Pending internal access to memory space |
| cke | output | 1 | Memory clock-enable pin |
| cmd_pall | output | 1 | Precharge-all command strobe |
| cmd_sre | output | 1 | Self-refresh entry command strobe |
| sr_active | output | 1 | Status: self-refresh entered and not yet fully exited |
| aref_block | output | 1 | Suppresses the auto-refresh scheduler |
| dll_rst | output | 1 | Holds the on-chip DLL in reset |
| clk_en | output | NCLK | Per-clock gating enables (1 = clock runs) |
| acc_go | output | 1 | One-cycle grant releasing the held access |

## Verification
The hardest case to reach is a clock-stop write that lands inside the short window where it is accepted. Reaching it at the ports means polling sr_active the way software would, writing on the cycle the status first appears, and then ending residency while some clocks are still stopped, so that the ungate step of the exit can be seen. The bench does this with a long residency count and acc_req held low until after the writes. A separate sweep covers every precharge, residency and recovery count from 0 to 3, with the access arriving early or late. In that sweep each output is predicted cycle by cycle from the phase lengths, and an ignored write is injected in the precharge wait.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_PALL   = 4'd1,
    ST_TRP    = 4'd2,
    ST_ENTER  = 4'd3,
    ST_SELF   = 4'd4,
    ST_UNGATE = 4'd5,
    ST_CKEUP  = 4'd6,
    ST_RECOV  = 4'd7,
    ST_GRANT  = 4'd8
  } sr_state_e;

  // A wait of count c lasts max(c,1) cycles: the timer is expired at 0 or 1.
  function automatic bit cnt_expired(int unsigned c);
    return c <= 1;
  endfunction

  // Number of cycles spent in a timed state for a programmed count.
  function automatic int unsigned wait_len(int unsigned n);
    return (n < 2) ? 1 : n;
  endfunction

endpackage

// File: rtl/sr_timer.sv
module sr_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  import sr_pkg::*;

  logic [CW-1:0] cnt;

  assign done = cnt_expired(32'(cnt));

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (load)    cnt <= load_val;
    else if (!done)   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sr_fsm.sv
module sr_fsm #(
  parameter int CW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              acc_req,
  input  logic              tmr_done,
  input  logic [CW-1:0]     cfg_trp,
  input  logic [CW-1:0]     cfg_tras,
  input  logic [CW-1:0]     cfg_txsr,
  output sr_pkg::sr_state_e state,
  output logic              tmr_load,
  output logic [CW-1:0]     tmr_val,
  output logic              ev_exit
);
  import sr_pkg::*;

  sr_state_e nxt;

  assign ev_exit = (state == ST_SELF) && tmr_done && acc_req;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE:   if (ev_start) nxt = ST_PALL;
      ST_PALL:   begin nxt = ST_TRP; tmr_load = 1'b1; tmr_val = cfg_trp; end
      ST_TRP:    if (tmr_done) nxt = ST_ENTER;
      ST_ENTER:  begin nxt = ST_SELF; tmr_load = 1'b1; tmr_val = cfg_tras; end
      ST_SELF:   if (ev_exit) nxt = ST_UNGATE;
      ST_UNGATE: nxt = ST_CKEUP;
      ST_CKEUP:  begin nxt = ST_RECOV; tmr_load = 1'b1; tmr_val = cfg_txsr; end
      ST_RECOV:  if (tmr_done) nxt = ST_GRANT;
      ST_GRANT:  nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/sr_clk_gate.sv
module sr_clk_gate #(
  parameter int NCLK = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [NCLK-1:0] wdis,
  input  logic            accept,
  input  logic            release_all,
  output logic [NCLK-1:0] clk_en
);
  for (genvar k = 0; k < NCLK; k++) begin : g_clk
    logic stop_q;
    always_ff @(posedge clk) begin
      if (!rst_n)              stop_q <= 1'b0;
      else if (release_all)    stop_q <= 1'b0;
      else if (wr && accept)   stop_q <= wdis[k];
    end
    assign clk_en[k] = ~stop_q;
  end
endmodule

// File: rtl/sr_power_ctrl.sv
module sr_power_ctrl #(
  parameter int CW   = 4,
  parameter int NCLK = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_we,
  input  logic            ctl_srf,
  input  logic [NCLK-1:0] ctl_clkdis,
  input  logic [CW-1:0]   cfg_trp,
  input  logic [CW-1:0]   cfg_tras,
  input  logic [CW-1:0]   cfg_txsr,
  input  logic            acc_req,
  output logic            cke,
  output logic            cmd_pall,
  output logic            cmd_sre,
  output logic            sr_active,
  output logic            aref_block,
  output logic            dll_rst,
  output logic [NCLK-1:0] clk_en,
  output logic            acc_go
);
  import sr_pkg::*;

  sr_state_e     state;
  logic          ev_start;
  logic          ev_exit;
  logic          tmr_load;
  logic          tmr_done;
  logic [CW-1:0] tmr_val;
  logic          gate_window;

  assign ev_start    = ctl_we && ctl_srf && (state == ST_IDLE);
  assign gate_window = (state == ST_ENTER) || (state == ST_SELF);

  sr_fsm #(.CW(CW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_start (ev_start),
    .acc_req  (acc_req),
    .tmr_done (tmr_done),
    .cfg_trp  (cfg_trp),
    .cfg_tras (cfg_tras),
    .cfg_txsr (cfg_txsr),
    .state    (state),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .ev_exit  (ev_exit)
  );

  sr_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sr_clk_gate #(.NCLK(NCLK)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (ctl_we),
    .wdis        (ctl_clkdis),
    .accept      (gate_window),
    .release_all (ev_exit),
    .clk_en      (clk_en)
  );

  always_comb begin
    cke        = 1'b1;
    cmd_pall   = 1'b0;
    cmd_sre    = 1'b0;
    sr_active  = 1'b0;
    aref_block = 1'b0;
    dll_rst    = 1'b0;
    acc_go     = 1'b0;
    unique case (state)
      ST_IDLE:   ;
      ST_PALL:   begin cmd_pall = 1'b1; aref_block = 1'b1; end
      ST_TRP:    aref_block = 1'b1;
      ST_ENTER:  begin cmd_sre = 1'b1; cke = 1'b0; sr_active = 1'b1;
                       aref_block = 1'b1; dll_rst = 1'b1; end
      ST_SELF,
      ST_UNGATE: begin cke = 1'b0; sr_active = 1'b1; aref_block = 1'b1;
                       dll_rst = 1'b1; end
      ST_CKEUP:  begin sr_active = 1'b1; aref_block = 1'b1; dll_rst = 1'b1; end
      ST_RECOV:  begin sr_active = 1'b1; aref_block = 1'b1; end
      ST_GRANT:  acc_go = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/sr_power_ctrl_chk.sv
module sr_power_ctrl_chk #(
  parameter int NCLK = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cke,
  input logic            cmd_pall,
  input logic            cmd_sre,
  input logic            sr_active,
  input logic            aref_block,
  input logic            dll_rst,
  input logic [NCLK-1:0] clk_en,
  input logic            acc_go
);
  p_pall_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pall |=> !cmd_pall && aref_block);

  p_sre_cke_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sre |-> !cke && !cmd_pall);

  p_aref_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> aref_block);

  p_ack_on_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sre |-> sr_active);

  p_gate_only_in_sr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(&clk_en) |-> sr_active && !cke);

  p_cke_rise_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_active && $rose(cke)) |-> (&clk_en) && dll_rst);

  p_grant_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |-> cke && !sr_active && !aref_block && !dll_rst && $past(sr_active));

  p_dll_in_sr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> dll_rst);
endmodule

bind sr_power_ctrl sr_power_ctrl_chk #(.NCLK(NCLK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cke        (cke),
  .cmd_pall   (cmd_pall),
  .cmd_sre    (cmd_sre),
  .sr_active  (sr_active),
  .aref_block (aref_block),
  .dll_rst    (dll_rst),
  .clk_en     (clk_en),
  .acc_go     (acc_go)
);

// File: tb/sr_power_ctrl_tb.sv
`timescale 1ns/1ps
module sr_power_ctrl_tb;
  localparam int CW   = 4;
  localparam int NCLK = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ctl_we = 1'b0;
  logic            ctl_srf = 1'b0;
  logic [NCLK-1:0] ctl_clkdis = '0;
  logic [CW-1:0]   cfg_trp = '0;
  logic [CW-1:0]   cfg_tras = '0;
  logic [CW-1:0]   cfg_txsr = '0;
  logic            acc_req = 1'b0;
  logic            cke, cmd_pall, cmd_sre, sr_active, aref_block, dll_rst, acc_go;
  logic [NCLK-1:0] clk_en;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sr_power_ctrl #(.CW(CW), .NCLK(NCLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_srf(ctl_srf),
    .ctl_clkdis(ctl_clkdis), .cfg_trp(cfg_trp), .cfg_tras(cfg_tras),
    .cfg_txsr(cfg_txsr), .acc_req(acc_req), .cke(cke), .cmd_pall(cmd_pall),
    .cmd_sre(cmd_sre), .sr_active(sr_active), .aref_block(aref_block),
    .dll_rst(dll_rst), .clk_en(clk_en), .acc_go(acc_go)
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  function automatic int wl(int n);
    return (n >= 2) ? n : 1;
  endfunction

  // phases: 0 idle,1 pall,2 trp,3 enter,4 self,5 ungate,6 ckeup,7 recov,8 grant
  function automatic int phase_at(int j, int l1, int ls, int l3);
    int b;
    b = 2 + l1 + ls;
    if (j == 0) return 1;
    if (j < 1 + l1) return 2;
    if (j == 1 + l1) return 3;
    if (j < b) return 4;
    if (j == b) return 5;
    if (j == b + 1) return 6;
    if (j < b + 2 + l3) return 7;
    if (j == b + 2 + l3) return 8;
    return 0;
  endfunction

  task automatic check_phase(int p, string ctx);
    chk(cmd_pall,   (p == 1) ? 1 : 0, {"R2 cmd_pall ", ctx});
    chk(cmd_sre,    (p == 3) ? 1 : 0, {"R3 cmd_sre ", ctx});
    chk(cke,        (p >= 3 && p <= 5) ? 0 : 1, {"R4 cke ", ctx});
    chk(aref_block, (p >= 1 && p <= 7) ? 1 : 0, {"R4 aref_block ", ctx});
    chk(sr_active,  (p >= 3 && p <= 7) ? 1 : 0, {"R5 sr_active ", ctx});
    chk(dll_rst,    (p >= 3 && p <= 6) ? 1 : 0, {"R10 dll_rst ", ctx});
    chk(acc_go,     (p == 8) ? 1 : 0, {"R8 acc_go ", ctx});
    chk(int'(clk_en), (1 << NCLK) - 1, {"R7 clk_en ", ctx});
  endtask

  // Full sequence with acc_req raised at index q; optional ignored write in the precharge wait.
  task automatic run_seq(int trp, int tras, int txsr, int q, bit poke);
    int l1, l2, l3, a, ls, total, p;
    string ctx;
    l1 = wl(trp); l2 = wl(tras); l3 = wl(txsr);
    a  = (q > 2 + l1) ? q - (2 + l1) : 0;
    ls = (l2 > a + 1) ? l2 : a + 1;
    total = 2 + l1 + ls + 3 + l3;
    cfg_trp = CW'(trp); cfg_tras = CW'(tras); cfg_txsr = CW'(txsr);
    ctx = $sformatf("trp=%0d tras=%0d txsr=%0d q=%0d", trp, tras, txsr, q);
    @(negedge clk);
    ctl_we = 1'b1; ctl_srf = 1'b1; ctl_clkdis = '0;
    @(negedge clk);
    ctl_we = 1'b0; ctl_srf = 1'b0;
    for (int j = 0; j <= total; j++) begin
      if (j == q) acc_req = 1'b1;
      p = phase_at(j, l1, ls, l3);
      check_phase(p, $sformatf("%s j=%0d", ctx, j));
      if (poke && j == 1) begin
        // R9 and R7: srf and clock-stop write in precharge wait must be ignored
        ctl_we = 1'b1; ctl_srf = 1'b1; ctl_clkdis = '1;
      end else begin
        ctl_we = 1'b0; ctl_srf = 1'b0; ctl_clkdis = '0;
      end
      if (p == 8) acc_req = 1'b0;
      @(negedge clk);
    end
    acc_req = 1'b0;
  endtask

  // Clock-stop scenario: poll status, stop clocks, then exit.
  task automatic run_clk_stop();
    int guard;
    cfg_trp = 4'd2; cfg_tras = 4'd10; cfg_txsr = 4'd2;
    @(negedge clk);
    ctl_we = 1'b1; ctl_srf = 1'b1; ctl_clkdis = '0;
    @(negedge clk);
    ctl_we = 1'b0; ctl_srf = 1'b0;
    guard = 0;
    while (!sr_active && guard < 20) begin @(negedge clk); guard++; end
    chk(sr_active, 1, "R5 status seen while polling");
    ctl_we = 1'b1; ctl_clkdis = 2'b11;
    @(negedge clk);
    ctl_we = 1'b0;
    chk(int'(clk_en), 0, "R7 both clocks stopped after acknowledged write");
    chk(cke, 0, "R4 cke low while clocks stopped");
    ctl_we = 1'b1; ctl_clkdis = 2'b01; ctl_srf = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0; ctl_srf = 1'b0;
    chk(int'(clk_en), 2, "R7 per-clock stop bit 0 only");
    chk(cmd_pall, 0, "R9 srf write in self-refresh ignored");
    chk(sr_active, 1, "R9 status kept after srf write");
    acc_req = 1'b1;
    guard = 0;
    while (clk_en != 2'b11 && guard < 40) begin @(negedge clk); guard++; end
    chk(int'(clk_en), 3, "R8 clocks released first on exit");
    chk(cke, 0, "R8 cke still low in ungate cycle");
    chk(dll_rst, 1, "R8 dll in reset in ungate cycle");
    @(negedge clk);
    chk(cke, 1, "R8 cke raised second");
    chk(dll_rst, 1, "R10 dll still reset when cke rises");
    @(negedge clk);
    chk(dll_rst, 0, "R8 dll released in recovery");
    chk(sr_active, 1, "R5 status held in recovery");
    @(negedge clk);
    @(negedge clk);
    chk(acc_go, 1, "R8 grant after recovery");
    chk(sr_active, 0, "R5 status clear in grant cycle");
    chk(aref_block, 0, "R4 refresh suppression released with status");
    acc_req = 1'b0;
    @(negedge clk);
    chk(acc_go, 0, "R8 grant is one cycle");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cke, 1, "R1 cke after reset");
    chk(int'(clk_en), 3, "R1 clk_en after reset");
    chk(int'({cmd_pall, cmd_sre, sr_active, aref_block, dll_rst, acc_go}), 0,
        "R1 strobes and status after reset");

    // R7: clock-stop write while idle is ignored
    ctl_we = 1'b1; ctl_clkdis = 2'b11;
    @(negedge clk);
    ctl_we = 1'b0; ctl_clkdis = '0;
    chk(int'(clk_en), 3, "R7 idle clock-stop write ignored");

    // R9: access while idle gives no grant and no entry
    acc_req = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(acc_go, 0, "R9 idle access no grant");
      chk(cmd_pall, 0, "R9 idle access no precharge");
    end
    acc_req = 1'b0;

    // R6 and timing sweep: access already pending
    for (int trp = 0; trp < 4; trp++)
      for (int tras = 0; tras < 4; tras++)
        for (int txsr = 0; txsr < 4; txsr++)
          run_seq(trp, tras, txsr, 0, trp == 2);

    // R6: access arriving after residency expires
    for (int tras = 0; tras < 4; tras++)
      for (int trp = 0; trp < 3; trp++)
        run_seq(trp, tras, 1, 2 + wl(trp) + wl(tras) + 2, 1'b0);

    run_clk_stop();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule